// File: doc/BRIEF.md
# Program-Counter Delta Correlation Prefetcher

This block watches a stream of cache-miss accesses, each tagged with the program counter of the instruction that made it, and predicts which cache lines that instruction will touch next. A small direct-mapped table, selected by a hash of the program counter, keeps one record per tracked instruction. Each record holds the last line address seen, the signed line deltas between successive accesses and the last line it caused to be prefetched.

On each access the block works out the new delta and appends it to the record's history. It then looks for an earlier place where the same pair of deltas occurred, using the oldest such place. The deltas that followed that earlier pair are replayed one after another onto the current line address to form candidate prefetch addresses. A candidate is dropped if an earlier prefetch from the same record already covered it, or if it leaves the 4 KB page of the current access. The survivors are handed out one per cycle on a valid/ready request port. While candidates are pending the access port is not ready.

Top module: `pcdc_prefetch`

## Requirements
- R1: After reset `pf_valid` is 0, `acc_ready` is 1 and every table entry is empty, so the first access from any program counter produces no request.
- R2: An access whose entry is empty or holds a different program counter overwrites that entry with the new program counter and line address, empties its delta history, forgets its last prefetched line and issues no request.
- R3: On a hit the delta is the current line number (address bits 31:6) minus the stored one. A zero delta changes nothing and issues nothing. A delta outside -128..127 stores the new line, empties the history and issues nothing.
- R4: The history keeps the six most recent non-zero deltas. The newest pair (second newest, newest) is compared with every earlier adjacent pair, overlapping allowed, and the oldest match is used; with fewer than three deltas or no match, nothing is issued.
- R5: The candidates are the current line plus the first, the first two, and so on of the deltas that follow the matched pair, issued in that order as line-aligned byte addresses (bits 5:0 zero).
- R6: If a candidate equals the entry's last prefetched line, that candidate and all before it are dropped; the last prefetched line becomes the last request issued by the access, and stays unchanged when none is issued.
- R7: A candidate whose bits 31:12 differ from those of the current access is dropped, and later candidates are still considered.
- R8: Requests appear the cycle after the access is accepted, one per `pf_valid`/`pf_ready` handshake, with `pf_addr` held while stalled, and `acc_ready` is 0 while any request is pending.
- R9: The entry index is `pc[5:2] ^ pc[9:6]`, so two program counters with the same index keep evicting each other and never predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Block can take an access |
| acc_pc | input | 32 | Program counter of the access |
| acc_addr | input | 32 | Byte address of the access |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Request taken by the next level |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
The stale-prefetch filter and the page filter both act on the same replayed candidate list in one access, so a single burst can lose its front to the first and its tail to the second. Constant strides of every size from -8 to 8 lines, started mid-page and run past the page edge, make repeated candidates and page crossings land in the same access. The issued sequence, including its length, is compared against a list computed from the requirements for every access, with the request port stalled in a fixed pattern.

// File: rtl/pcdc_prefetch.sv
module pcdc_prefetch #(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST   = 6,
  parameter int DW     = 8,
  parameter int LINE_B = 6,
  parameter int PAGE_B = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int ENT    = 1 << IDX_W;
  localparam int LINE_W = ADDR_W - LINE_B;
  localparam int NC     = HIST - 2;
  localparam int CW     = $clog2(HIST + 1);
  localparam int PG_LO  = PAGE_B - LINE_B;

  logic [ENT-1:0]    v_q;
  logic [PC_W-1:0]   tag_q  [ENT];
  logic [LINE_W-1:0] prev_q [ENT];
  logic [DW-1:0]     hist_q [ENT][HIST];
  logic [CW-1:0]     cnt_q  [ENT];
  logic              lpv_q  [ENT];
  logic [LINE_W-1:0] lp_q   [ENT];

  logic [LINE_W-1:0] cq [NC];
  logic [NC-1:0]     mq;

  logic [IDX_W-1:0]  idx;
  logic [LINE_W-1:0] cur_line, diff, run, fin, pa;
  logic              hit, zero, fits, accept, found;
  logic [DW-1:0]     nh [HIST];
  logic [DW-1:0]     d;
  logic [CW-1:0]     ncnt;
  logic [LINE_W-1:0] cand [NC];
  logic [NC-1:0]     live, keep, imask, clr;
  int                fp, hitpos;
  logic              unused_bits;

  assign unused_bits = ^acc_addr[LINE_B-1:0];
  assign idx      = acc_pc[2 +: IDX_W] ^ acc_pc[2+IDX_W +: IDX_W];
  assign cur_line = acc_addr[ADDR_W-1:LINE_B];
  assign hit      = v_q[idx] && (tag_q[idx] == acc_pc);
  assign diff     = cur_line - prev_q[idx];
  assign zero     = (diff == '0);
  assign fits     = (&diff[LINE_W-1:DW-1]) | ~(|diff[LINE_W-1:DW-1]);
  assign acc_ready = ~|mq;
  assign accept   = acc_valid && acc_ready;
  assign pf_valid = |mq;
  assign pf_addr  = {pa, {LINE_B{1'b0}}};

  always_comb begin
    for (int k = 0; k < HIST-1; k++) nh[k] = hist_q[idx][k+1];
    nh[HIST-1] = diff[DW-1:0];
    ncnt = (cnt_q[idx] == CW'(HIST)) ? cnt_q[idx] : cnt_q[idx] + CW'(1);

    found = 1'b0;
    fp    = 0;
    for (int p = HIST-3; p >= 0; p--)
      if (p >= HIST - int'(ncnt) && nh[p] == nh[HIST-2] && nh[p+1] == nh[HIST-1]) begin
        found = 1'b1;
        fp    = p;
      end

    run = cur_line;
    for (int k = 0; k < NC; k++) begin
      d       = '0;
      live[k] = 1'b0;
      for (int j = 0; j < HIST; j++)
        if (found && j == fp + 2 + k) begin
          d       = nh[j];
          live[k] = 1'b1;
        end
      if (live[k]) run = run + {{(LINE_W-DW){d[DW-1]}}, d};
      cand[k] = run;
    end

    hitpos = -1;
    for (int k = 0; k < NC; k++)
      if (live[k] && lpv_q[idx] && cand[k] == lp_q[idx]) hitpos = k;

    for (int k = 0; k < NC; k++)
      keep[k] = live[k] && (k > hitpos) &&
                (cand[k][LINE_W-1:PG_LO] == cur_line[LINE_W-1:PG_LO]);

    imask = (hit && !zero && fits) ? keep : '0;

    fin = cur_line;
    for (int k = 0; k < NC; k++)
      if (imask[k]) fin = cand[k];
  end

  always_comb begin
    pa  = '0;
    clr = '0;
    for (int k = NC-1; k >= 0; k--)
      if (mq[k]) begin
        pa  = cq[k];
        clr = NC'(1) << k;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      mq  <= '0;
      for (int e = 0; e < ENT; e++) begin
        tag_q[e]  <= '0;
        prev_q[e] <= '0;
        cnt_q[e]  <= '0;
        lpv_q[e]  <= 1'b0;
        lp_q[e]   <= '0;
        for (int h = 0; h < HIST; h++) hist_q[e][h] <= '0;
      end
      for (int k = 0; k < NC; k++) cq[k] <= '0;
    end else begin
      if (pf_valid && pf_ready) mq <= mq & ~clr;
      if (accept) begin
        mq <= imask;
        for (int k = 0; k < NC; k++) cq[k] <= cand[k];
        if (!hit) begin
          v_q[idx]    <= 1'b1;
          tag_q[idx]  <= acc_pc;
          prev_q[idx] <= cur_line;
          cnt_q[idx]  <= '0;
          lpv_q[idx]  <= 1'b0;
        end else if (!zero && !fits) begin
          prev_q[idx] <= cur_line;
          cnt_q[idx]  <= '0;
        end else if (!zero) begin
          prev_q[idx] <= cur_line;
          cnt_q[idx]  <= ncnt;
          for (int h = 0; h < HIST; h++) hist_q[idx][h] <= nh[h];
          if (|imask) begin
            lpv_q[idx] <= 1'b1;
            lp_q[idx]  <= fin;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcdc_prefetch_chk.sv
module pcdc_prefetch_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 6,
  parameter int PAGE_B = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  logic [ADDR_W-PAGE_B-1:0] page_q;
  logic                     unused_chk;
  assign unused_chk = ^acc_addr[PAGE_B-1:0];

  always_ff @(posedge clk)
    if (!rst_n) page_q <= '0;
    else if (acc_valid && acc_ready) page_q <= acc_addr[ADDR_W-1:PAGE_B];

  a_r7_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[ADDR_W-1:PAGE_B] == page_q);
  a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[LINE_B-1:0] == '0);
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
  a_r8_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(acc_valid && acc_ready));
  a_r8_busy_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !acc_ready);
endmodule

bind pcdc_prefetch pcdc_prefetch_chk #(.ADDR_W(ADDR_W), .LINE_B(LINE_B), .PAGE_B(PAGE_B)) chk_i (.*);

// File: tb/pcdc_prefetch_tb_top.sv
module pcdc_prefetch_tb_top;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, pf_ready = 0;
  logic acc_ready, pf_valid;
  logic [31:0] acc_pc = 0, acc_addr = 0, pf_addr;
  int n_vec = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pcdc_prefetch dut_i (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_pc(acc_pc), .acc_addr(acc_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  // reference model state, built from the requirements
  bit          m_v  [16];
  logic [31:0] m_t  [16];
  int          m_p  [16];
  int          m_h  [16][6];
  int          m_n  [16];
  bit          m_lv [16];
  int          m_lp [16];
  int          e_n;
  int          e_ln [4];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] pc, input logic [31:0] addr);
    int ix, ln, df, n, fp, last, run, c[4], nc;
    ix = int'(pc[5:2] ^ pc[9:6]);   // R9 index hash
    ln = int'(addr[31:6]);
    e_n = 0;
    if (!m_v[ix] || m_t[ix] != pc) begin   // R2
      m_v[ix] = 1; m_t[ix] = pc; m_p[ix] = ln; m_n[ix] = 0; m_lv[ix] = 0;
      return;
    end
    df = ln - m_p[ix];
    if (df == 0) return;                   // R3 zero delta
    m_p[ix] = ln;
    if (df > 127 || df < -128) begin m_n[ix] = 0; return; end
    if (m_n[ix] < 6) begin m_h[ix][m_n[ix]] = df; m_n[ix]++; end
    else begin
      for (int k = 0; k < 5; k++) m_h[ix][k] = m_h[ix][k+1];
      m_h[ix][5] = df;
    end
    n = m_n[ix];
    fp = -1;
    for (int i = n-3; i >= 0; i--)        // R4 oldest match wins
      if (m_h[ix][i] == m_h[ix][n-2] && m_h[ix][i+1] == m_h[ix][n-1]) fp = i;
    if (fp < 0) return;
    nc = n - 2 - fp;
    run = ln;
    for (int k = 0; k < nc; k++) begin run += m_h[ix][fp+2+k]; c[k] = run; end
    last = -1;
    for (int k = 0; k < nc; k++) if (m_lv[ix] && c[k] == m_lp[ix]) last = k;   // R6
    for (int k = last+1; k < nc; k++)
      if ((c[k] >> 6) == (ln >> 6)) begin e_ln[e_n] = c[k]; e_n++; end        // R7
    if (e_n > 0) begin m_lv[ix] = 1; m_lp[ix] = e_ln[e_n-1]; end
  endtask

  task automatic access(input logic [31:0] pc, input logic [31:0] addr, input string tag);
    int got, guard;
    model(pc, addr);
    @(negedge clk);
    check(acc_ready === 1'b1 && pf_valid === 1'b0, {tag, " R8 idle before access"}, {31'b0, acc_ready}, 32'h1);
    acc_valid = 1; acc_pc = pc; acc_addr = addr;
    @(negedge clk);
    acc_valid = 0;
    got = 0; guard = 0;
    while (pf_valid === 1'b1 && guard < 60) begin
      pf_ready = (cyc % 3) != 1;
      if (pf_ready) begin
        if (got < e_n) check(pf_addr == {e_ln[got][25:0], 6'b0}, {tag, " R5 request address"},
                             pf_addr, {e_ln[got][25:0], 6'b0});
        got++;
      end
      @(negedge clk);
      guard++;
    end
    pf_ready = 0;
    check(got == e_n, {tag, " R5 request count"}, got, e_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int lcg;
    repeat (3) @(negedge clk);
    check(pf_valid === 1'b0 && acc_ready === 1'b1, "R1 reset outputs", {30'b0, pf_valid, acc_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    check(pf_valid === 1'b0 && acc_ready === 1'b1, "R1 after reset", {30'b0, pf_valid, acc_ready}, 32'h1);

    // R6/R7: every constant stride from -8 to 8 lines, mid-page start, runs past the page edge
    for (int s = -8; s <= 8; s++) begin
      if (s == 0) continue;
      a = 32'h4000_0800 + 32'(s * 4096 * 4);
      for (int i = 0; i < 14; i++) access(32'h0000_1000 + 32'((s + 8) * 4), a + 32'(i * s * 64), "R6 R7 stride");
    end

    // R4/R5: alternating deltas 1,3
    a = 32'h5000_0000;
    for (int i = 0; i < 10; i++) begin access(32'h0000_2010, a, "R5 alternating"); a += (i % 2 == 0) ? 64 : 192; end

    // R4: increasing deltas never repeat as a pair
    a = 32'h5100_0000;
    for (int i = 0; i < 7; i++) begin access(32'h0000_2020, a, "R4 no match"); a += 32'((i + 1) * 64); end

    // R3: zero delta and out-of-range delta
    a = 32'h5200_0400;
    for (int i = 0; i < 5; i++) begin access(32'h0000_2030, a, "R3 build"); a += 64; end
    access(32'h0000_2030, a - 64, "R3 zero delta");
    access(32'h0000_2030, a - 64 + 32'd30, "R3 zero delta same line");
    access(32'h0000_2030, a, "R3 after zero");
    access(32'h0000_2030, a + 32'(200 * 64), "R3 large delta");
    for (int i = 1; i < 6; i++) access(32'h0000_2030, a + 32'((200 + i) * 64), "R3 rebuild");
    access(32'h0000_2030, a + 32'((200 + 5 - 128) * 64), "R3 delta -128");

    // R9: aliasing program counters evict each other
    for (int i = 0; i < 8; i++) begin
      access(32'h0000_0040, 32'h6000_0000 + 32'(i * 64), "R9 alias A");
      access(32'h0000_0004, 32'h6100_0000 + 32'(i * 64), "R9 alias B");
    end
    // R2: tag change on a trained entry
    for (int i = 0; i < 6; i++) access(32'h0000_0040, 32'h6200_0000 + 32'(i * 64), "R2 train");
    access(32'h0000_0440, 32'h6300_0000, "R2 replace");
    access(32'h0000_0040, 32'h6200_0180, "R2 old pc gone");

    // irregular mixes over several program counters
    lcg = 7;
    for (int p = 0; p < 4; p++) begin
      a = 32'h7000_0800 + 32'(p * 32'h10_0000);
      for (int i = 0; i < 60; i++) begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fff_ffff;
        access(32'h0000_3000 + 32'(p * 4), a, "R4 R5 R6 mixed");
        case ((lcg >> 16) % 4)
          0: a += 64;
          1: a += 128;
          2: a -= 64;
          default: a += 192;
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule